// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog counter controlled through a small register window. Software writes a reload value and a reset-pulse length, then starts the watchdog by writing two fixed key words in a row to the control register. Once running, the counter steps down by one on every strobe of a timebase tick input (nominally a 40 MHz enable). Software keeps the system alive by repeating the start pair, which reloads the counter. A different key pair halts the counter and reloads it.

When the count runs out, the block stops, sets a sticky expiry flag in a status byte and drives a reset output for a programmed number of timebase ticks. Reading the control register returns the live count, so software can see how much time is left. Writes that break a key pair cancel it, so a stray write cannot start or stop the watchdog.

Top module: `wdk_watchdog`

## Requirements
- R1: After synchronous reset, the counter is stopped at zero, the reload, pulse-length and status registers read zero, and `wdt_reset_o` is low.
- R2: A write of 0xFF00 followed by the very next write of 0x00FF, both to the control register (address 1), loads the counter from the reload register and starts it. The new count is readable from the second cycle after the second write's edge.
- R3: Repeating the start pair while the watchdog is running reloads the counter from the reload register and keeps it running.
- R4: A write of 0xEE00 followed by the very next write of 0x00EE to the control register stops the counter and loads it from the reload register.
- R5: A key pair is cancelled by a wrong second word or by any write that comes between its two words, including a write to another register. A cancelled pair changes neither the count nor whether the counter runs.
- R6: While running, the count drops by exactly one per cycle in which `tick_i` is high. Cycles without a tick leave it unchanged. While stopped, ticks do not change it.
- R7: A tick that takes the count from 1 (or from 0) ends at zero and stops the counter. Bit 3 of the status register (address 3) is set one cycle after that tick.
- R8: `wdt_reset_o` rises one cycle after expiry and stays high for exactly L ticks. L is the pulse-length register (address 2), sampled at expiry. L = 0 gives no pulse.
- R9: Writing 1 to status bit 3 clears it, and writing 0 there leaves it alone. Status bits 0 to 2 always read zero. A new expiry in the same cycle as a clear leaves the bit set.
- R10: A write to the reload register (address 0) does not change the running count. The new value is used at the next start or stop.
- R11: Reads are combinational from `addr_i`: address 0 gives the reload value, 1 the live count, 2 the pulse length, and 3 the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Timebase enable, one strobe per tick |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select for read and write |
| wdata_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Read data for `addr_i` |
| wdt_reset_o | output | 1 | Reset pulse driven on expiry |

## Verification
Each result has a fixed latency. A completed key pair changes the count two edges after the write of its second word: one edge registers the command and one loads the counter. A tick changes the count at its own edge. The status flag and the reset pulse change one edge after the expiring tick. Every check goes through a queue that a monitor drains at the falling edge, so each check covers exactly one cycle. The driver places each check in the cycle where these latencies put the result, including the cycle just before the change, to show that nothing moves early.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

    localparam logic [15:0] KEY_RUN_A  = 16'hFF00;
    localparam logic [15:0] KEY_RUN_B  = 16'h00FF;
    localparam logic [15:0] KEY_HALT_A = 16'hEE00;
    localparam logic [15:0] KEY_HALT_B = 16'h00EE;

    localparam int unsigned FLAG_BIT = 3;

    typedef enum logic [1:0] {
        REG_RELOAD = 2'd0,
        REG_CTRL   = 2'd1,
        REG_PLEN   = 2'd2,
        REG_STAT   = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ARM_NONE = 2'd0,
        ARM_RUN  = 2'd1,
        ARM_HALT = 2'd2
    } arm_e;

    typedef struct packed {
        logic run;
        logic halt;
    } key_cmd_t;

    // A control word that opens a key pair, or none
    function automatic arm_e opener(input logic [15:0] w);
        if (w == KEY_RUN_A)       return ARM_RUN;
        else if (w == KEY_HALT_A) return ARM_HALT;
        else                      return ARM_NONE;
    endfunction

endpackage

// File: rtl/wdk_keyseq.sv
module wdk_keyseq
    import wdk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ctrl_wr_i,
    input  logic        any_wr_i,
    input  logic [15:0] word_i,
    output key_cmd_t    cmd_o
);
    arm_e     arm_q;
    key_cmd_t cmd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q <= ARM_NONE;
            cmd_q <= '0;
        end else begin
            cmd_q <= '0;
            if (ctrl_wr_i) begin
                if (arm_q == ARM_RUN && word_i == KEY_RUN_B) begin
                    cmd_q.run <= 1'b1;
                    arm_q     <= ARM_NONE;
                end else if (arm_q == ARM_HALT && word_i == KEY_HALT_B) begin
                    cmd_q.halt <= 1'b1;
                    arm_q      <= ARM_NONE;
                end else begin
                    arm_q <= opener(word_i);
                end
            end else if (any_wr_i) begin
                arm_q <= ARM_NONE;
            end
        end
    end

    assign cmd_o = cmd_q;

    p_one_cmd_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_q.run, cmd_q.halt}));

    p_run_needs_arm_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_q.run |-> $past(arm_q) == ARM_RUN);

    p_halt_needs_arm_r4: assert property (@(posedge clk) disable iff (rst)
        cmd_q.halt |-> $past(arm_q) == ARM_HALT);

endmodule

// File: rtl/wdk_counter.sv
module wdk_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic             halt_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] count_o,
    output logic             active_o,
    output logic             expire_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] count_q;
    logic             active_q;
    logic             expire_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q  <= '0;
            active_q <= 1'b0;
            expire_q <= 1'b0;
        end else begin
            expire_q <= 1'b0;
            if (run_i) begin
                count_q  <= reload_i;
                active_q <= 1'b1;
            end else if (halt_i) begin
                count_q  <= reload_i;
                active_q <= 1'b0;
            end else if (active_q && tick_i) begin
                if (count_q <= ONE) begin
                    count_q  <= '0;
                    active_q <= 1'b0;
                    expire_q <= 1'b1;
                end else begin
                    count_q <= count_q - ONE;
                end
            end
        end
    end

    assign count_o  = count_q;
    assign active_o = active_q;
    assign expire_o = expire_q;

    p_start_load_r2: assert property (@(posedge clk) disable iff (rst)
        run_i |=> (count_q == $past(reload_i)) && active_q);

    p_halt_load_r4: assert property (@(posedge clk) disable iff (rst)
        halt_i && !run_i |=> (count_q == $past(reload_i)) && !active_q);

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !active_q && !run_i && !halt_i |=> $stable(count_q));

    p_step_r6: assert property (@(posedge clk) disable iff (rst)
        active_q && tick_i && !run_i && !halt_i && count_q > ONE
        |=> count_q == $past(count_q) - ONE);

    p_expire_zero_r7: assert property (@(posedge clk) disable iff (rst)
        expire_q |-> count_q == '0 && !active_q);

endmodule

// File: rtl/wdk_pulse.sv
module wdk_pulse #(
    parameter int unsigned PLEN_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              fire_i,
    input  logic [PLEN_W-1:0] len_i,
    output logic              pulse_o
);
    logic [PLEN_W-1:0] rem_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
        end else if (fire_i) begin
            rem_q <= len_i;
        end else if (tick_i && rem_q != '0) begin
            rem_q <= rem_q - PLEN_W'(1);
        end
    end

    assign pulse_o = (rem_q != '0);

    p_pulse_load_r8: assert property (@(posedge clk) disable iff (rst)
        fire_i |=> rem_q == $past(len_i));

    p_pulse_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !fire_i && !tick_i |=> $stable(rem_q));

endmodule

// File: rtl/wdk_watchdog.sv
module wdk_watchdog
    import wdk_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned PLEN_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [1:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              wdt_reset_o
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(addr_i);

    logic [CNT_W-1:0]  reload_q;
    logic [PLEN_W-1:0] plen_q;
    logic              flag_q;

    key_cmd_t          cmd;
    logic [CNT_W-1:0]  count;
    logic              active;
    logic              expire;

    logic wr_ctrl, wr_reload, wr_plen, wr_stat;
    assign wr_ctrl   = wr_en_i && (sel == REG_CTRL);
    assign wr_reload = wr_en_i && (sel == REG_RELOAD);
    assign wr_plen   = wr_en_i && (sel == REG_PLEN);
    assign wr_stat   = wr_en_i && (sel == REG_STAT);

    wdk_keyseq u_keys (
        .clk       (clk),
        .rst       (rst),
        .ctrl_wr_i (wr_ctrl),
        .any_wr_i  (wr_en_i),
        .word_i    (wdata_i[15:0]),
        .cmd_o     (cmd)
    );

    wdk_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (tick_i),
        .run_i    (cmd.run),
        .halt_i   (cmd.halt),
        .reload_i (reload_q),
        .count_o  (count),
        .active_o (active),
        .expire_o (expire)
    );

    wdk_pulse #(.PLEN_W(PLEN_W)) u_pulse (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick_i),
        .fire_i  (expire),
        .len_i   (plen_q),
        .pulse_o (wdt_reset_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '0;
            plen_q   <= '0;
            flag_q   <= 1'b0;
        end else begin
            if (wr_reload) reload_q <= wdata_i[CNT_W-1:0];
            if (wr_plen)   plen_q   <= wdata_i[PLEN_W-1:0];
            if (expire)
                flag_q <= 1'b1;
            else if (wr_stat && wdata_i[FLAG_BIT])
                flag_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (sel)
            REG_RELOAD: rd_data_o = DATA_W'(reload_q);
            REG_CTRL:   rd_data_o = DATA_W'(count);
            REG_PLEN:   rd_data_o = DATA_W'(plen_q);
            default:    rd_data_o = DATA_W'({flag_q, 3'b000});
        endcase
    end

    p_flag_set_r7: assert property (@(posedge clk) disable iff (rst)
        expire |=> flag_q);

    p_reload_wr_r10: assert property (@(posedge clk) disable iff (rst)
        wr_reload |=> reload_q == $past(wdata_i[CNT_W-1:0]));

    p_run_after_expire_r7: assert property (@(posedge clk) disable iff (rst)
        expire && !cmd.run |-> !active);

endmodule

// File: tb/wdk_watchdog_tb_top.sv
`timescale 1ns/100ps
module wdk_watchdog_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rd_data;
    logic        wdt_rst;

    always #2.5 clk = ~clk;

    wdk_watchdog dut_i (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (tick),
        .wr_en_i     (wr_en),
        .addr_i      (addr),
        .wdata_i     (wdata),
        .rd_data_o   (rd_data),
        .wdt_reset_o (wdt_rst)
    );

    typedef struct {
        bit          sel_rst;
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    int    total = 0;
    int    bad   = 0;
    bit    done  = 1'b0;

    // Monitor: drain expected items once per cycle, away from the clock edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [15:0] obs;
            it  = sb_q.pop_front();
            obs = it.sel_rst ? {15'h0, wdt_rst} : rd_data;
            total++;
            if (obs !== it.exp) begin
                bad++;
                $display("FAIL %s actual=%h expected=%h", it.tag, obs, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        step();
        wr_en = 1'b0;
    endtask

    task automatic pulse_tick();
        tick = 1'b1;
        step();
        tick = 1'b0;
    endtask

    // Each check observes the current cycle and then consumes it
    task automatic chk_rd(input logic [1:0] a, input logic [15:0] e, input string tag);
        item_t it;
        addr = a;
        it.sel_rst = 1'b0; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        step();
    endtask

    task automatic chk_rst(input logic e, input string tag);
        item_t it;
        it.sel_rst = 1'b1; it.exp = {15'h0, e}; it.tag = tag;
        sb_q.push_back(it);
        step();
    endtask

    localparam logic [1:0] A_RLD = 2'd0, A_CTL = 2'd1, A_LEN = 2'd2, A_STA = 2'd3;

    initial begin
        step(); step(); step();
        rst = 1'b0;
        chk_rd(A_CTL, 16'h0, "R1 count");
        chk_rd(A_RLD, 16'h0, "R1 reload");
        chk_rd(A_STA, 16'h0, "R1 status");
        chk_rst(1'b0, "R1 reset out");

        wr(A_RLD, 16'd5);
        wr(A_LEN, 16'd3);
        chk_rd(A_RLD, 16'd5, "R11 reload read");
        chk_rd(A_LEN, 16'd3, "R11 length read");

        // start pair
        wr(A_CTL, 16'hFF00);
        wr(A_CTL, 16'h00FF);
        chk_rd(A_CTL, 16'd0, "R2 not loaded early");
        chk_rd(A_CTL, 16'd5, "R2 loaded");
        step(); step(); step();
        chk_rd(A_CTL, 16'd5, "R6 no tick no change");
        pulse_tick(); pulse_tick();
        chk_rd(A_CTL, 16'd3, "R6 two ticks");

        // kick
        wr(A_CTL, 16'hFF00);
        wr(A_CTL, 16'h00FF);
        step();
        chk_rd(A_CTL, 16'd5, "R3 kick reload");
        pulse_tick();
        chk_rd(A_CTL, 16'd4, "R3 still running");

        // wrong second word
        wr(A_CTL, 16'hFF00);
        wr(A_CTL, 16'h1234);
        step();
        chk_rd(A_CTL, 16'd4, "R5 wrong second word");
        // intervening write to another register
        wr(A_CTL, 16'hFF00);
        wr(A_RLD, 16'd7);
        wr(A_CTL, 16'h00FF);
        step();
        chk_rd(A_CTL, 16'd4, "R5 intervening write");
        chk_rd(A_CTL, 16'd4, "R10 reload write leaves count");

        // stop pair
        wr(A_CTL, 16'hEE00);
        wr(A_CTL, 16'h00EE);
        step();
        chk_rd(A_CTL, 16'd7, "R4 stop reload");
        pulse_tick(); pulse_tick();
        chk_rd(A_CTL, 16'd7, "R4 stopped ignores ticks");

        // restart, then a broken stop pair
        wr(A_CTL, 16'hFF00);
        wr(A_CTL, 16'h00FF);
        step();
        pulse_tick();
        chk_rd(A_CTL, 16'd6, "R10 new reload used at start");
        wr(A_CTL, 16'hEE00);
        wr(A_CTL, 16'h00FF);
        step();
        chk_rd(A_CTL, 16'd6, "R5 broken stop pair");
        pulse_tick();
        chk_rd(A_CTL, 16'd5, "R5 still running");

        // expiry with a 3-tick pulse
        wr(A_RLD, 16'd2);
        wr(A_CTL, 16'hFF00);
        wr(A_CTL, 16'h00FF);
        step();
        pulse_tick();
        pulse_tick();
        chk_rd(A_STA, 16'h0000, "R7 flag not yet set");
        chk_rd(A_STA, 16'h0008, "R7 flag set");
        chk_rd(A_CTL, 16'd0, "R7 count zero");
        chk_rst(1'b1, "R8 pulse high");
        pulse_tick();
        chk_rst(1'b1, "R8 pulse after tick 1");
        pulse_tick();
        chk_rst(1'b1, "R8 pulse after tick 2");
        pulse_tick();
        chk_rst(1'b0, "R8 pulse ends after tick 3");
        chk_rd(A_CTL, 16'd0, "R7 stopped after expiry");

        // status write-one-to-clear
        wr(A_STA, 16'h0000);
        chk_rd(A_STA, 16'h0008, "R9 write zero no effect");
        wr(A_STA, 16'h0007);
        chk_rd(A_STA, 16'h0008, "R9 low bits ignored");
        wr(A_STA, 16'h0008);
        chk_rd(A_STA, 16'h0000, "R9 cleared");

        // zero-length pulse
        wr(A_LEN, 16'd0);
        wr(A_RLD, 16'd1);
        wr(A_CTL, 16'hFF00);
        wr(A_CTL, 16'h00FF);
        step();
        pulse_tick();
        chk_rst(1'b0, "R8 expiry cycle");
        chk_rst(1'b0, "R8 zero length no pulse");
        chk_rd(A_STA, 16'h0008, "R7 flag on second expiry");

        done = 1'b1;
        step();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog timeout actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule